// File: doc/BRIEF.md
# Translation Buffer with Physically Tagged Data Cache

This block turns a 32-bit virtual address into a physical address through a small fully associative translation buffer, then uses that physical address to read a direct-mapped data cache. One request is accepted per cycle. The response appears in the next cycle and carries the translation outcome, the cache outcome, the physical address and the data word.

The page is 4 KB. The upper 20 address bits are the page number, and the low 12 bits pass through translation unchanged. An external agent writes page mappings into the buffer through a refill port and writes cache words through a fill port. Page-table walks, fault handling, memory behind the cache and eviction write-back all live outside the block. Misses are only reported.

The buffer depth is the parameter `TLB_N` (64 by default). The cache depth is `2**IDX_W` words. The default `IDX_W` of 8 keeps elaboration small. Setting it to 14 gives a 16K-word cache with a 16-bit tag.

Top module: `xlat_ptag_cache`

## Requirements
- R1: Reset invalidates every translation entry and every cache word, and sets the replacement pointer to 0. While reset is held, `rsp_valid` is 0. After reset, any lookup reports a translation miss. A mapping refilled after reset finds no cache hit until a new fill is made.
- R2: A request sampled with `req_valid` high at a clock edge is answered with `rsp_valid` high in the cycle after that edge. When the translation hits, `rsp_paddr` equals the entry's 20-bit physical page number followed by virtual address bits 11:0. At most one entry matches any page number.
- R3: On a translation miss, `tlb_miss` is 1 and `tlb_hit`, `cache_hit`, `cache_miss`, `rsp_dirty`, `rsp_paddr` and `rsp_data` are all 0. The cache result is never used in this case.
- R4: A cache fill writes the word at index = address bits `IDX_W+1:2`, with tag = address bits 31:`IDX_W+2`, and marks it valid. A later translated access to the same physical word reports `cache_hit` and returns that data on `rsp_data`.
- R5: When the translation hits and the indexed cache word is invalid or its tag differs, `cache_miss` is 1 and `rsp_data` is 0. Whenever `rsp_valid` is 1, exactly one of `tlb_miss`, `cache_hit` and `cache_miss` is 1.
- R6: A store that hits in the translation buffer sets that entry's dirty flag at the end of its response cycle. A load leaves the flag unchanged. `rsp_dirty` shows the flag as it stood before the current access. A refill clears the flag.
- R7: A refill goes into the lowest-numbered invalid entry when one exists. Because of this, the first `TLB_N` refills after reset, each with a distinct page number, all remain resident.
- R8: When every entry is valid, a refill replaces the entry named by the round-robin pointer. The pointer advances by one, wrapping modulo `TLB_N`, on every refill. After `TLB_N` refills from reset, the next refill therefore displaces the first mapping written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address of the lookup |
| tlb_wr_en | input | 1 | Write one page mapping |
| tlb_wr_vpn | input | 20 | Virtual page number of the mapping |
| tlb_wr_ppn | input | 20 | Physical page number of the mapping |
| cfill_en | input | 1 | Write one cache word |
| cfill_waddr | input | 30 | Physical word address (physical address bits 31:2) |
| cfill_data | input | 32 | Word to store |
| rsp_valid | output | 1 | Response present |
| tlb_hit | output | 1 | Translation found |
| tlb_miss | output | 1 | Translation not found |
| cache_hit | output | 1 | Cache word valid with matching tag |
| cache_miss | output | 1 | Translated, but cache word absent |
| rsp_dirty | output | 1 | Dirty flag of the matched entry before this access |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_data | output | 32 | Cached word on a cache hit |

## Verification
The assertions assume that page numbers in the translation buffer are always unique. The agent driving the refill port must never write a page number that is already resident, or the one-match property fails. The bench meets this by keeping its own picture of the buffer and drawing random page numbers until it finds one that is not resident. The bench also keeps refills, fills and lookups in separate cycles. Each lookup is then checked against a table state that a same-edge write has not changed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int PG_OFF_W = 12;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PPN_W    = 20;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 2;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } xlat_ent_t;

    typedef struct packed {
        logic            valid;
        logic            store;
        logic [VA_W-1:0] vaddr;
    } lkup_req_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_store,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_dirty
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        xlat_ent_t [N-1:0] ents;
        logic [IW-1:0]     rr;
    } cam_state_t;

    cam_state_t st_d, st_q;
    logic [N-1:0]  match;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] inv_idx;
    logic          inv_found;
    logic [IW-1:0] victim;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = st_q.ents[g].valid && (st_q.ents[g].vpn == lk_vpn);
    end

    always_comb begin
        hit_idx   = '0;
        inv_idx   = '0;
        inv_found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
            if (!st_q.ents[i].valid) begin
                inv_idx   = IW'(i);
                inv_found = 1'b1;
            end
        end
        hit       = |match;
        hit_ppn   = st_q.ents[hit_idx].ppn;
        hit_dirty = st_q.ents[hit_idx].dirty;
        victim    = inv_found ? inv_idx : st_q.rr;

        st_d = st_q;
        if (lk_valid && lk_store && hit) st_d.ents[hit_idx].dirty = 1'b1;
        if (wr_en) begin
            st_d.ents[victim].valid = 1'b1;
            st_d.ents[victim].dirty = 1'b0;
            st_d.ents[victim].vpn   = wr_vpn;
            st_d.ents[victim].ppn   = wr_ppn;
            st_d.rr = (st_q.rr == IW'(N - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: page numbers must be unique among valid entries
    p_one_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R6: a store hit leaves the matched entry dirty
    p_store_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_store && hit && !wr_en) |=> st_q.ents[$past(hit_idx)].dirty);

    // R7: a refill lands as a valid clean entry holding the new page
    p_refill_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.ents[$past(victim)].valid && !st_q.ents[$past(victim)].dirty
                   && st_q.ents[$past(victim)].vpn == $past(wr_vpn)));
endmodule

// File: rtl/dcache_dm.sv
module dcache_dm
    import xlat_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VA_W-BYTE_W-1:0]   rd_waddr,
    input  logic                     fill_en,
    input  logic [VA_W-BYTE_W-1:0]   fill_waddr,
    input  logic [WORD_W-1:0]        fill_data,
    output logic                     rd_hit,
    output logic [WORD_W-1:0]        rd_data
);
    localparam int TAG_W = VA_W - BYTE_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_d, vld_q;
    logic [TAG_W-1:0]  tag_mem  [DEPTH];
    logic [WORD_W-1:0] data_mem [DEPTH];

    logic [IDX_W-1:0] rd_idx, fill_idx;
    logic [TAG_W-1:0] rd_tag, fill_tag;

    always_comb begin
        rd_idx   = rd_waddr[IDX_W-1:0];
        rd_tag   = rd_waddr[VA_W-BYTE_W-1:IDX_W];
        fill_idx = fill_waddr[IDX_W-1:0];
        fill_tag = fill_waddr[VA_W-BYTE_W-1:IDX_W];
        rd_hit   = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
        rd_data  = data_mem[rd_idx];
        vld_d    = vld_q;
        if (fill_en) vld_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx]  <= fill_tag;
            data_mem[fill_idx] <= fill_data;
        end
    end

    // R4: a filled word is valid from the next cycle
    p_fill_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_idx)]);
endmodule

// File: rtl/xlat_ptag_cache.sv
module xlat_ptag_cache
    import xlat_pkg::*;
#(
    parameter int TLB_N = 64,
    parameter int IDX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_store,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic                   tlb_wr_en,
    input  logic [VPN_W-1:0]       tlb_wr_vpn,
    input  logic [PPN_W-1:0]       tlb_wr_ppn,
    input  logic                   cfill_en,
    input  logic [VA_W-BYTE_W-1:0] cfill_waddr,
    input  logic [WORD_W-1:0]      cfill_data,
    output logic                   rsp_valid,
    output logic                   tlb_hit,
    output logic                   tlb_miss,
    output logic                   cache_hit,
    output logic                   cache_miss,
    output logic                   rsp_dirty,
    output logic [VA_W-1:0]        rsp_paddr,
    output logic [WORD_W-1:0]      rsp_data
);
    lkup_req_t req_d, req_q;
    logic              cam_hit, cam_dirty, c_hit;
    logic [PPN_W-1:0]  cam_ppn;
    logic [WORD_W-1:0] c_data;
    logic [VA_W-1:0]   paddr;

    always_comb begin
        req_d.valid = req_valid;
        req_d.store = req_store;
        req_d.vaddr = req_vaddr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    xlat_cam #(.N(TLB_N)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (req_q.valid),
        .lk_store  (req_q.store),
        .lk_vpn    (req_q.vaddr[VA_W-1:PG_OFF_W]),
        .wr_en     (tlb_wr_en),
        .wr_vpn    (tlb_wr_vpn),
        .wr_ppn    (tlb_wr_ppn),
        .hit       (cam_hit),
        .hit_ppn   (cam_ppn),
        .hit_dirty (cam_dirty)
    );

    assign paddr = {cam_ppn, req_q.vaddr[PG_OFF_W-1:0]};

    dcache_dm #(.IDX_W(IDX_W)) u_dc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_waddr   (paddr[VA_W-1:BYTE_W]),
        .fill_en    (cfill_en),
        .fill_waddr (cfill_waddr),
        .fill_data  (cfill_data),
        .rd_hit     (c_hit),
        .rd_data    (c_data)
    );

    always_comb begin
        rsp_valid  = req_q.valid;
        tlb_hit    = req_q.valid && cam_hit;
        tlb_miss   = req_q.valid && !cam_hit;
        cache_hit  = tlb_hit && c_hit;
        cache_miss = tlb_hit && !c_hit;
        rsp_dirty  = tlb_hit && cam_dirty;
        rsp_paddr  = tlb_hit ? paddr : '0;
        rsp_data   = cache_hit ? c_data : '0;
    end

    // R2: every accepted request is answered next cycle
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: no cache result without a translation
    p_chit_needs_thit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_hit || cache_miss) |-> tlb_hit);

    // R5: exactly one outcome per response
    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({tlb_miss, cache_hit, cache_miss}) == 1));
endmodule

// File: tb/xlat_ptag_cache_test.sv
module xlat_ptag_cache_test;
    localparam int CLK_P = 10;
    localparam int N     = 64;
    localparam int IDX_W = 8;
    localparam int DEPTH = 1 << IDX_W;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_store = 0;
    logic [31:0] req_vaddr = '0;
    logic        tlb_wr_en = 0;
    logic [19:0] tlb_wr_vpn = '0, tlb_wr_ppn = '0;
    logic        cfill_en = 0;
    logic [29:0] cfill_waddr = '0;
    logic [31:0] cfill_data = '0;
    logic        rsp_valid, tlb_hit, tlb_miss, cache_hit, cache_miss, rsp_dirty;
    logic [31:0] rsp_paddr, rsp_data;

    always #(CLK_P/2) clk = ~clk;

    xlat_ptag_cache #(.TLB_N(N), .IDX_W(IDX_W)) uut (.*);

    int checks = 0, fails = 0;

    // bench model
    bit          m_val [N];
    bit          m_dirty [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_ppn [N];
    int          m_rr;
    bit          c_val [DEPTH];
    logic [21:0] c_tag [DEPTH];
    logic [31:0] c_dat [DEPTH];

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dirty[i] = 0; end
        for (int i = 0; i < DEPTH; i++) c_val[i] = 0;
        m_rr = 0;
    endfunction

    function automatic int model_find(input logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < N; i++) if (!m_val[i]) return i;
        return m_rr;
    endfunction

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn);
        int v;
        v = model_victim();
        m_val[v] = 1; m_dirty[v] = 0; m_vpn[v] = vpn; m_ppn[v] = ppn;
        m_rr = (m_rr + 1) % N;
        @(negedge clk);
        tlb_wr_en = 1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
        @(negedge clk);
        tlb_wr_en = 0;
    endtask

    task automatic fill(input logic [31:0] pa, input logic [31:0] d);
        c_val[pa[IDX_W+1:2]] = 1;
        c_tag[pa[IDX_W+1:2]] = pa[31:IDX_W+2];
        c_dat[pa[IDX_W+1:2]] = d;
        @(negedge clk);
        cfill_en = 1; cfill_waddr = pa[31:2]; cfill_data = d;
        @(negedge clk);
        cfill_en = 0;
    endtask

    task automatic lookup(input logic [31:0] va, input bit st, input string r);
        int hi;
        logic [31:0] pa;
        bit ch;
        hi = model_find(va[31:12]);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_store = st;
        @(negedge clk);
        req_valid = 0;
        chk({r, " rsp_valid"}, rsp_valid, 1);
        if (hi < 0) begin
            chk({r, " miss flags"}, {tlb_miss, tlb_hit, cache_hit, cache_miss, rsp_dirty}, 5'b10000);
            chk({r, " miss paddr/data"}, {rsp_paddr, rsp_data}, 64'h0);
        end else begin
            pa = {m_ppn[hi], va[11:0]};
            ch = c_val[pa[IDX_W+1:2]] && c_tag[pa[IDX_W+1:2]] == pa[31:IDX_W+2];
            chk({r, " tlb flags"}, {tlb_hit, tlb_miss}, 2'b10);
            chk({r, " paddr"}, rsp_paddr, pa);
            chk({r, " dirty"}, rsp_dirty, m_dirty[hi]);
            chk({r, " cache flags"}, {cache_hit, cache_miss}, {ch, !ch});
            chk({r, " data"}, rsp_data, ch ? c_dat[pa[IDX_W+1:2]] : 32'h0);
            if (st) m_dirty[hi] = 1;
        end
    endtask

    function automatic logic [19:0] fresh_vpn();
        logic [19:0] v;
        do v = 20'($urandom); while (model_find(v) >= 0);
        return v;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", rsp_valid, 0);
        rst_n = 1;

        // R1: empty after reset
        lookup(32'h1234_5678, 0, "R1");
        lookup(32'h0000_0000, 1, "R1");

        // R2 / R3: basic translation
        refill(20'h00AB1, 20'h7C001);
        refill(20'hFFFFF, 20'h00002);
        lookup(32'h00AB_1FFC, 0, "R2");
        lookup(32'hFFFF_F004, 0, "R2");
        lookup(32'h00AB_2000, 0, "R3");

        // R4 / R5: cache behaviour on translated address
        fill(32'h7C00_1FFC, 32'hDEAD_BEEF);
        lookup(32'h00AB_1FFC, 0, "R4");
        lookup(32'h00AB_1FF8, 0, "R5");
        fill(32'h1C00_1FFC, 32'h0BAD_F00D);  // same index, other tag
        lookup(32'h00AB_1FFC, 0, "R5");
        fill(32'h0000_2004, 32'h1111_2222);
        lookup(32'hFFFF_F004, 0, "R4");

        // R6: dirty semantics
        lookup(32'hFFFF_F010, 0, "R6");
        lookup(32'hFFFF_F010, 0, "R6");
        lookup(32'hFFFF_F010, 1, "R6");
        lookup(32'hFFFF_F010, 0, "R6");

        // R7: fill the rest; every mapping stays resident
        for (int i = 2; i < N; i++) refill(20'h40000 + 20'(i), 20'h30000 + 20'(i));
        lookup(32'h00AB_1000, 0, "R7");
        lookup(32'hFFFF_F000, 0, "R7");
        for (int i = 2; i < N; i++) lookup({20'h40000 + 20'(i), 12'h008}, 0, "R7");

        // R8: round robin now starts at entry 0 (first mapping written)
        refill(20'h55555, 20'h66666);
        lookup(32'h00AB_1FFC, 0, "R8");
        lookup(32'h5555_5ABC, 0, "R8");
        lookup(32'hFFFF_F004, 0, "R8");
        refill(20'h55556, 20'h66667);
        lookup(32'hFFFF_F004, 0, "R8");
        lookup(32'h5555_6000, 1, "R8");

        // random mix
        for (int it = 0; it < 3000; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op == 0) begin
                refill(fresh_vpn(), 20'($urandom));
            end else if (op < 3) begin
                int s;
                s = int'($urandom % N);
                if (m_val[s]) fill({m_ppn[s], 10'($urandom), 2'b00}, $urandom);
                else          fill({$urandom} & 32'hFFFF_FFFC, $urandom);
            end else begin
                int s;
                logic [31:0] va;
                s = int'($urandom % N);
                if (($urandom % 10) < 7 && m_val[s]) va = {m_vpn[s], 12'($urandom)};
                else                                  va = $urandom;
                lookup(va, ($urandom % 10) < 3, "R2");
            end
        end

        // R1: reset clears translations and cache words
        fill(32'h7C00_1FFC, 32'hCAFE_0001);
        @(negedge clk);
        rst_n = 0;
        model_clear();
        repeat (2) @(negedge clk);
        chk("R1 rsp_valid in reset", rsp_valid, 0);
        rst_n = 1;
        lookup(32'h00AB_1FFC, 0, "R1");
        refill(20'h00AB1, 20'h7C001);
        lookup(32'h00AB_1FFC, 0, "R1");
        chk("R1 cache cleared", {cache_hit, cache_miss}, 2'b01);

        finish_run();
    end
endmodule